// File: doc/BRIEF.md
# Pin Controller with Banked Interrupt Status

This block manages a parameterized set of general-purpose pins (64 by default). Each pin owns one 32-bit configuration word. The word holds:

- the output data bit,
- a 3-bit mode that selects output drive or one of several input trigger styles,
- a two-bit alternate-function select,
- a pull setting and an input-enable bit,
- a lock bit,
- a 3-bit interrupt group number,
- a few analog pad settings, which are only stored.

The block drives the pad output, the pad output enable, the pull and input-enable controls and the alternate-function select toward the pad ring. It receives pad levels that are already synchronized.

Input pins raise events that depend on their mode: level high, level low, rising edge, falling edge or either edge. Each event sets a pending bit in the status bank of the group the pin currently names. Software reads a bank as 32-bit words and acknowledges by writing ones. Each group drives one interrupt line, which is the OR of its pending bits that belong to pins still routed to that group.

Access uses a plain single-cycle register bus that never stalls. A write takes effect at the clock edge where `wr_en` is high. A read captures its word at the edge where `rd_en` is high and presents it on `rd_data` with `rd_valid` one cycle later. There is no back-pressure in either direction, so `rd_en` and `wr_en` may be asserted in any cycle.

Top module: `pinio_ctrl`

## Requirements
- R1: After reset every configuration word reads 0x0000000E: mode 7, and every other field is zero. Every pending bit is 0, every `irq` line is 0 and every `pad_oe` bit is 0.
- R2: The configuration word of pin n is at byte address 4*n. Writes keep only the bits in mask 0x00E78FEF; all other bits read 0. The fields are data bit 0, mode 3:1, alternate select 6:5, pull 8:7, input enable 9, lock 21 and group 18:16.
- R3: When the mode is not 1, bit 0 of a configuration read returns the live pad level. When the mode is 1, bit 0 returns the stored data bit.
- R4: `pad_oe[n]` is 1 exactly when the mode is 1 and the alternate select is 0. `pad_out[n]` is the stored data bit. `periph_sel[2n+1:2n]` carries the alternate select.
- R5: Mode 2 (level high) and mode 3 (level low) set the pending bit in every cycle in which the level condition holds. An acknowledge written while the condition still holds therefore leaves the bit set.
- R6: Mode 4 (rising), mode 5 (falling) and mode 6 (either edge) set the pending bit once per edge. The edge is found by comparing the pad level with its value in the previous cycle, so a pad that stays at a level does not set the bit again after an acknowledge.
- R7: Writing a 1 to a pending bit clears it. Writing a 0 leaves it unchanged.
- R8: The pending word for group g and pins 32k to 32k+31 is at byte address 0x800 + 0x40*g + 4*k. Bit i of that word belongs to pin 32k+i. An event sets the bit only in the group that the pin's group field names at that moment.
- R9: `irq[g]` is the OR of the pending bits of group g whose pin currently has group field g. Moving a pin to another group masks its old pending bit from `irq[g]` without clearing that bit.
- R10: Once the lock bit of a pin reads 1, all later writes to that pin's configuration word are ignored until reset.
- R11: Reads of unmapped addresses return 0. These include pins at or above NPINS, groups at or above NGROUPS, words beyond the pin count and misaligned addresses. Modes 1 and 7 never set a pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte address |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid one cycle after `rd_en` |
| rd_valid | output | 1 | Marks the cycle that carries read data |
| pad_in | input | NPINS | Synchronized pad levels |
| pad_out | output | NPINS | Pad output values |
| pad_oe | output | NPINS | Pad output enables |
| pad_ie | output | NPINS | Pad input enables |
| pad_pull | output | 2*NPINS | Pull code per pin |
| periph_sel | output | 2*NPINS | Alternate-function select per pin |
| irq | output | NGROUPS | One interrupt line per group |

## Verification
The bench attacks the acknowledge race in level mode. A design that let the clear win over the set would drop a level interrupt while the pad is still asserted. It also checks that an edge-mode acknowledge stays cleared while the pad holds its level; a design that treated edge modes as levels would fire again at once. The bench moves a pending pin to another group. A design that cleared the old bit, or that still OR-ed it into the old interrupt line, would be caught. Further checks expose a design that ignores the lock bit, returns the stored data bit in place of the live pad level, or aliases unmapped addresses onto real registers.

// File: rtl/pinio_pkg.sv
package pinio_pkg;

  localparam int ADDR_W = 12;

  typedef enum logic [2:0] {
    PM_RSVD   = 3'd0,
    PM_DRIVE  = 3'd1,
    PM_LVL_HI = 3'd2,
    PM_LVL_LO = 3'd3,
    PM_RISE   = 3'd4,
    PM_FALL   = 3'd5,
    PM_ANY    = 3'd6,
    PM_INPUT  = 3'd7
  } pin_mode_e;

  localparam int F_DATA  = 0;
  localparam int F_MODE  = 1;
  localparam int F_PSEL  = 5;
  localparam int F_PULL  = 7;
  localparam int F_IE    = 9;
  localparam int F_GRP   = 16;
  localparam int F_LOCK  = 21;

  localparam logic [31:0] CFG_WMASK = 32'h00E7_8FEF;
  localparam logic [31:0] CFG_RESET = 32'h0000_000E;

  function automatic logic trig_hit(pin_mode_e m, logic now, logic was);
    case (m)
      PM_LVL_HI: return now;
      PM_LVL_LO: return !now;
      PM_RISE:   return now && !was;
      PM_FALL:   return !now && was;
      PM_ANY:    return now ^ was;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pinio_cfg_bank.sv
module pinio_cfg_bank
  import pinio_pkg::*;
#(
  parameter int NPINS  = 64,
  parameter int PIN_AW = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en_i,
  input  logic [PIN_AW-1:0]      wr_idx_i,
  input  logic [31:0]            wdata_i,
  output logic [NPINS-1:0][31:0] cfg_o
);

  logic [NPINS-1:0][31:0] cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NPINS; p++) cfg_q[p] <= CFG_RESET;
    end else if (wr_en_i) begin
      for (int p = 0; p < NPINS; p++) begin
        if (wr_idx_i == PIN_AW'(p) && !cfg_q[p][F_LOCK])
          cfg_q[p] <= wdata_i & CFG_WMASK;
      end
    end
  end

  assign cfg_o = cfg_q;

  for (genvar p = 0; p < NPINS; p++) begin : g_lock_chk
    AST_LOCK_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cfg_q[p][F_LOCK]) |-> $stable(cfg_q[p])); // R10
  end

endmodule

// File: rtl/pinio_trig_detect.sv
module pinio_trig_detect
  import pinio_pkg::*;
#(
  parameter int NPINS = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPINS-1:0]      lvl_i,
  input  logic [NPINS-1:0][2:0] mode_i,
  output logic [NPINS-1:0]      evt_o
);

  logic [NPINS-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_i;
  end

  always_comb begin
    for (int p = 0; p < NPINS; p++)
      evt_o[p] = trig_hit(pin_mode_e'(mode_i[p]), lvl_i[p], prev_q[p]);
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_quiet_chk
    AST_QUIET_MODES: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i[p] == PM_DRIVE || mode_i[p] == PM_INPUT) |-> !evt_o[p]); // R11
  end

endmodule

// File: rtl/pinio_pend_bank.sv
module pinio_pend_bank #(
  parameter int NPINS   = 64,
  parameter int NGROUPS = 4,
  parameter int GRP_W   = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NPINS-1:0]             evt_i,
  input  logic [NPINS-1:0][GRP_W-1:0]  pin_grp_i,
  input  logic                         clr_en_i,
  input  logic [4:0]                   clr_grp_i,
  input  logic [3:0]                   clr_word_i,
  input  logic [31:0]                  clr_bits_i,
  output logic [NGROUPS-1:0][NPINS-1:0] pend_o,
  output logic [NGROUPS-1:0]           irq_o
);

  logic [NGROUPS-1:0][NPINS-1:0] pend_q, set_m, clr_m, routed_m;

  always_comb begin
    for (int g = 0; g < NGROUPS; g++) begin
      for (int p = 0; p < NPINS; p++) begin
        set_m[g][p]    = evt_i[p] && (pin_grp_i[p] == GRP_W'(g));
        clr_m[g][p]    = clr_en_i && (clr_grp_i == 5'(g)) &&
                         (clr_word_i == 4'(p / 32)) && clr_bits_i[p % 32];
        routed_m[g][p] = pend_q[g][p] && (pin_grp_i[p] == GRP_W'(g));
      end
    end
  end

  // set has priority so a held level re-asserts over an acknowledge
  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_m) | set_m;
  end

  always_comb begin
    for (int g = 0; g < NGROUPS; g++) irq_o[g] = |routed_m[g];
  end

  assign pend_o = pend_q;

  for (genvar g = 0; g < NGROUPS; g++) begin : g_grp_chk
    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[g] |-> (|pend_q[g])); // R9
    for (genvar p = 0; p < NPINS; p++) begin : g_pin_chk
      AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        set_m[g][p] |=> pend_q[g][p]); // R5
      AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_m[g][p] && !set_m[g][p]) |=> !pend_q[g][p]); // R7
    end
  end

endmodule

// File: rtl/pinio_ctrl.sv
module pinio_ctrl
  import pinio_pkg::*;
#(
  parameter int NPINS   = 64,
  parameter int NGROUPS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [11:0]          addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rd_data,
  output logic                 rd_valid,
  input  logic [NPINS-1:0]     pad_in,
  output logic [NPINS-1:0]     pad_out,
  output logic [NPINS-1:0]     pad_oe,
  output logic [NPINS-1:0]     pad_ie,
  output logic [2*NPINS-1:0]   pad_pull,
  output logic [2*NPINS-1:0]   periph_sel,
  output logic [NGROUPS-1:0]   irq
);

  localparam int PIN_AW     = (NPINS > 1) ? $clog2(NPINS) : 1;
  localparam int PEND_WORDS = (NPINS + 31) / 32;
  localparam int GRP_W      = 3;

  logic [NPINS-1:0][31:0]        cfg;
  logic [NPINS-1:0][2:0]         mode_v;
  logic [NPINS-1:0][GRP_W-1:0]   grp_v;
  logic [NPINS-1:0]              evt;
  logic [NGROUPS-1:0][NPINS-1:0] pend;
  logic [NGROUPS-1:0][PEND_WORDS*32-1:0] pend_pad;

  // address decode
  logic [8:0]        word_idx;
  logic [PIN_AW-1:0] pin_idx;
  logic [4:0]        pend_grp;
  logic [3:0]        pend_word;
  logic              cfg_hit, pend_hit;

  assign word_idx  = addr[10:2];
  assign pin_idx   = word_idx[PIN_AW-1:0];
  assign pend_grp  = addr[10:6];
  assign pend_word = addr[5:2];
  assign cfg_hit   = !addr[11] && (addr[1:0] == 2'b00) && (word_idx < 9'(NPINS));
  assign pend_hit  = addr[11] && (addr[1:0] == 2'b00) &&
                     (pend_grp < 5'(NGROUPS)) && ({1'b0, pend_word} < 5'(PEND_WORDS));

  pinio_cfg_bank #(.NPINS(NPINS), .PIN_AW(PIN_AW)) i_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (wr_en && cfg_hit),
    .wr_idx_i (pin_idx),
    .wdata_i  (wdata),
    .cfg_o    (cfg)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    assign mode_v[p]            = cfg[p][F_MODE +: 3];
    assign grp_v[p]             = cfg[p][F_GRP +: GRP_W];
    assign pad_out[p]           = cfg[p][F_DATA];
    assign pad_ie[p]            = cfg[p][F_IE];
    assign pad_pull[2*p +: 2]   = cfg[p][F_PULL +: 2];
    assign periph_sel[2*p +: 2] = cfg[p][F_PSEL +: 2];
    assign pad_oe[p]            = (mode_v[p] == PM_DRIVE) && (cfg[p][F_PSEL +: 2] == 2'd0);
  end

  pinio_trig_detect #(.NPINS(NPINS)) i_trig (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (pad_in),
    .mode_i (mode_v),
    .evt_o  (evt)
  );

  pinio_pend_bank #(.NPINS(NPINS), .NGROUPS(NGROUPS), .GRP_W(GRP_W)) i_pend (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (evt),
    .pin_grp_i  (grp_v),
    .clr_en_i   (wr_en && pend_hit),
    .clr_grp_i  (pend_grp),
    .clr_word_i (pend_word),
    .clr_bits_i (wdata),
    .pend_o     (pend),
    .irq_o      (irq)
  );

  for (genvar g = 0; g < NGROUPS; g++) begin : g_pad
    assign pend_pad[g] = (PEND_WORDS*32)'(pend[g]);
  end

  // read path
  logic [31:0] rd_word;

  always_comb begin
    rd_word = '0;
    if (cfg_hit) begin
      rd_word = cfg[pin_idx];
      if (mode_v[pin_idx] != PM_DRIVE) rd_word[F_DATA] = pad_in[pin_idx];
    end else if (pend_hit) begin
      for (int g = 0; g < NGROUPS; g++)
        for (int k = 0; k < PEND_WORDS; k++)
          if (pend_grp == 5'(g) && pend_word == 4'(k))
            rd_word = pend_pad[g][k*32 +: 32];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_word;
    end
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_en && !cfg_hit && !pend_hit) |-> (rd_data == 32'd0)); // R11

  for (genvar p = 0; p < NPINS; p++) begin : g_oe_chk
    AST_ALT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (periph_sel[2*p +: 2] != 2'd0) |-> !pad_oe[p]); // R4
  end

endmodule

// File: tb/test_pinio_ctrl.sv
module test_pinio_ctrl;

  localparam int NP = 64;
  localparam int NG = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [11:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rd_data;
  logic          rd_valid;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe, pad_ie;
  logic [2*NP-1:0] pad_pull, periph_sel;
  logic [NG-1:0] irq;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  pinio_ctrl #(.NPINS(NP), .NGROUPS(NG)) i_pinio_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rd_data(rd_data), .rd_valid(rd_valid), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_ie(pad_ie), .pad_pull(pad_pull),
    .periph_sel(periph_sel), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic pad_set(input int p, input logic v);
    @(negedge clk);
    pad_in[p] = v;
    @(negedge clk);
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string req);
    logic [31:0] d;
    bus_rd(a, d);
    chk(d === exp, req, 64'(d), 64'(exp));
  endtask

  task automatic t_reset;
    rd_chk(12'h000, 32'h0000_000E, "R1 cfg pin0");
    rd_chk(12'h0FC, 32'h0000_000E, "R1 cfg pin63");
    rd_chk(12'h800, 32'h0, "R1 pending g0w0");
    rd_chk(12'h8C4, 32'h0, "R1 pending g3w1");
    chk(irq === '0, "R1 irq", 64'(irq), 64'h0);
    chk(pad_oe === '0, "R1 pad_oe", 64'(pad_oe), 64'h0);
  endtask

  task automatic t_cfg_rw;
    bus_wr(12'h028, 32'hFFFF_FFFF);          // pin 10, mode 7 after write, pad low
    rd_chk(12'h028, 32'h00E7_8FEE, "R2 write mask");
    chk(pad_pull[21:20] === 2'd3, "R2 pull field", 64'(pad_pull[21:20]), 64'd3);
    chk(pad_ie[10] === 1'b1, "R2 input enable", 64'(pad_ie[10]), 64'd1);
  endtask

  task automatic t_data_path;
    bus_wr(12'h008, 32'h0000_0003);          // pin 2 drive, data 1
    pad_set(2, 1'b0);
    rd_chk(12'h008, 32'h0000_0003, "R3 drive reads stored");
    chk(pad_oe[2] === 1'b1 && pad_out[2] === 1'b1, "R4 drive oe", 64'({pad_oe[2], pad_out[2]}), 64'h3);
    bus_wr(12'h008, 32'h0000_0023);          // alt select 1
    @(negedge clk);
    chk(pad_oe[2] === 1'b0, "R4 alt blocks oe", 64'(pad_oe[2]), 64'h0);
    chk(periph_sel[5:4] === 2'd1, "R4 periph_sel", 64'(periph_sel[5:4]), 64'h1);
    bus_wr(12'h008, 32'h0000_000F);          // mode 7, stored data 1
    rd_chk(12'h008, 32'h0000_000E, "R3 live low");
    pad_set(2, 1'b1);
    rd_chk(12'h008, 32'h0000_000F, "R3 live high");
    pad_set(2, 1'b0);
  endtask

  task automatic t_level;
    bus_wr(12'h010, 32'h0000_0004);          // pin 4 level high, group 0
    rd_chk(12'h800, 32'h0, "R5 no pending at low");
    pad_set(4, 1'b1);
    chk(irq[0] === 1'b1, "R5 irq level", 64'(irq[0]), 64'h1);
    bus_wr(12'h800, 32'h0000_0010);
    rd_chk(12'h800, 32'h0000_0010, "R5 ack while held");
    pad_set(4, 1'b0);
    bus_wr(12'h800, 32'h0000_0010);
    rd_chk(12'h800, 32'h0, "R7 ack after release");
    bus_wr(12'h010, 32'h0000_0006);          // level low, pad low
    rd_chk(12'h800, 32'h0000_0010, "R5 level low sets");
    pad_set(4, 1'b1);
    bus_wr(12'h800, 32'h0000_0010);
    rd_chk(12'h800, 32'h0, "R5 level low release clears");
    bus_wr(12'h010, 32'h0000_000E);
    pad_set(4, 1'b0);
  endtask

  task automatic t_edge;
    bus_wr(12'h00C, 32'h0001_0008);          // pin 3 rising, group 1
    pad_set(3, 1'b1);
    rd_chk(12'h840, 32'h0000_0008, "R6 rising sets");
    chk(irq === 4'b0010, "R6 irq group1", 64'(irq), 64'h2);
    bus_wr(12'h840, 32'h0000_0008);
    rd_chk(12'h840, 32'h0, "R6 no refire on held high");
    pad_set(3, 1'b0);
    pad_set(3, 1'b1);
    bus_wr(12'h840, 32'h0);
    rd_chk(12'h840, 32'h0000_0008, "R7 zero write keeps");
    bus_wr(12'h840, 32'h0000_0008);
    bus_wr(12'h00C, 32'h0001_000A);          // falling
    pad_set(3, 1'b0);
    rd_chk(12'h840, 32'h0000_0008, "R6 falling sets");
    bus_wr(12'h840, 32'h0000_0008);
    bus_wr(12'h00C, 32'h0001_000C);          // either
    pad_set(3, 1'b1);
    rd_chk(12'h840, 32'h0000_0008, "R6 either rise");
    bus_wr(12'h840, 32'h0000_0008);
    pad_set(3, 1'b0);
    rd_chk(12'h840, 32'h0000_0008, "R6 either fall");
    bus_wr(12'h840, 32'h0000_0008);
    bus_wr(12'h00C, 32'h0000_000E);
  endtask

  task automatic t_route;
    bus_wr(12'h0A0, 32'h0002_0004);          // pin 40 level high, group 2
    pad_set(40, 1'b1);
    rd_chk(12'h884, 32'h0000_0100, "R8 group2 word1 bit8");
    rd_chk(12'h804, 32'h0, "R8 not in group0");
    chk(irq === 4'b0100, "R9 irq group2", 64'(irq), 64'h4);
    bus_wr(12'h0A0, 32'h0003_000E);          // move to group 3, quiet
    @(negedge clk);
    chk(irq === 4'b0000, "R9 moved pin masked", 64'(irq), 64'h0);
    rd_chk(12'h884, 32'h0000_0100, "R9 old bit kept");
    bus_wr(12'h884, 32'h0000_0100);
    rd_chk(12'h884, 32'h0, "R7 group2 ack");
    pad_set(40, 1'b0);
  endtask

  task automatic t_lock;
    bus_wr(12'h014, 32'h0020_0003);          // pin 5 lock, drive, data 1
    bus_wr(12'h014, 32'h0000_000E);
    rd_chk(12'h014, 32'h0020_0003, "R10 locked write ignored");
    chk(pad_oe[5] === 1'b1, "R10 still driving", 64'(pad_oe[5]), 64'h1);
  endtask

  task automatic t_unmapped;
    rd_chk(12'h100, 32'h0, "R11 pin beyond NPINS");
    rd_chk(12'h900, 32'h0, "R11 group beyond NGROUPS");
    rd_chk(12'h808, 32'h0, "R11 word beyond pins");
    rd_chk(12'h001, 32'h0, "R11 misaligned");
    pad_set(5, 1'b1);                        // pin 5 drive mode
    pad_set(10, 1'b1);                       // pin 10 mode 7
    pad_set(10, 1'b0);
    rd_chk(12'h800, 32'h0, "R11 quiet modes no pending");
    pad_set(5, 1'b0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cfg_rw();
    t_data_path();
    t_level();
    t_edge();
    t_route();
    t_lock();
    t_unmapped();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule